// File: doc/BRIEF.md
# Sub-Word Load/Store Lane Aligner

This unit sits between the execute stage of a 32-bit processor and a data memory that is byte-addressed but read and written one whole word at a time. Each request carries an access code, a base register value and a signed 16-bit displacement. The unit adds the base and the displacement to form the byte address. It then either prepares a store for the memory or records a pending load.

For a store, the unit copies the byte or halfword across every lane of the write word. It raises only the write strobes that cover the addressed bytes. For a load, it remembers the size, signedness and lane. When the memory returns the word, the unit cuts out the addressed field and extends it to 32 bits. The extended value is presented one clock later with a valid pulse. The same result port also carries the upper-immediate value: the displacement placed in the top half of the word with the bottom half cleared.

Accesses that are not aligned to their size are flagged in the same cycle. Such an access issues no write strobe and produces no load result.

Top module: `mem_lane_align`

## Requirements
- R1: `mem_addr` equals `base_addr` plus the sign-extended `offset`, combinationally, for every request.
- R2: A byte store (code 8) copies `st_data[7:0]` into all four lanes. It raises only strobe bit k, where k = `mem_addr[1:0]`. Lanes are little-endian: lane k is bits 8k+7:8k.
- R3: A halfword store (code 9) copies `st_data[15:0]` into both halves. It raises strobe `4'b0011` when `mem_addr[1]`=0 and `4'b1100` when `mem_addr[1]`=1.
- R4: An aligned word store (code 10) raises strobe `4'b1111` and passes `st_data` through unchanged.
- R5: A misaligned access raises `req_err` in the same cycle, raises no strobe and leaves no load pending. A word access is misaligned when `mem_addr[1:0]`≠0. A halfword access is misaligned when `mem_addr[0]`=1.
- R6: A byte load returns the addressed byte of `rd_word`. Signed byte (code 0) sign-extends it to 32 bits; unsigned byte (code 1) zero-extends it.
- R7: A halfword load returns the halfword selected by address bit 1. Signed halfword (code 2) sign-extends it; unsigned halfword (code 3) zero-extends it.
- R8: A word load (code 4) returns `rd_word` unchanged.
- R9: `res_valid` pulses for exactly one cycle, one cycle after `rd_valid` is seen while a load is pending. A `rd_valid` with nothing pending produces no result.
- R10: Upper immediate (code 12) drives `res_data` = {`offset`, 16'h0000} with `res_valid` one cycle after the request. If a read return completes in that same cycle, the load result takes the slot and the upper-immediate value is dropped.
- R11: After reset, `res_valid` is 0 and no load is pending.
- R12: Loads, upper immediate and unassigned codes raise no write strobe. Unassigned codes produce neither an error nor a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Access code (see requirements) |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement; also the upper-immediate constant |
| st_data | input | 32 | Store source register |
| mem_addr | output | 32 | Effective byte address |
| mem_wstrb | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write word |
| req_err | output | 1 | Misaligned access flag |
| rd_valid | input | 1 | Memory read word present |
| rd_word | input | 32 | Word returned by memory |
| res_valid | output | 1 | Load or upper-immediate result valid |
| res_data | output | 32 | Extended result |

## Verification
The assertions assume that the memory returns at most one word for each accepted load, and only after that load's request cycle. They also assume that an unmatched `rd_valid` is simply ignored. The stimulus issues each load and gives its return one cycle later, and it adds some stray returns with nothing pending. A long pseudo-random phase mixes every code, every address alignment and random return pulses, including pulses that coincide with upper-immediate requests. The bench model follows the documented precedence rule for that collision.

// File: rtl/lane_pkg.sv
// Package: access codes and size classes shared by the lane aligner.
// Assumes a 4-bit access code; codes not listed are treated as no operation.
package lane_pkg;

    typedef enum logic [3:0] {
        OP_LB  = 4'd0,
        OP_LBU = 4'd1,
        OP_LH  = 4'd2,
        OP_LHU = 4'd3,
        OP_LW  = 4'd4,
        OP_SB  = 4'd8,
        OP_SH  = 4'd9,
        OP_SW  = 4'd10,
        OP_LUI = 4'd12
    } acc_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    // Size class of an access code.
    function automatic acc_size_e op_size(input acc_op_e op);
        case (op)
            OP_LB, OP_LBU, OP_SB: op_size = SZ_BYTE;
            OP_LH, OP_LHU, OP_SH: op_size = SZ_HALF;
            default:              op_size = SZ_WORD;
        endcase
    endfunction

    // True for the five load codes.
    function automatic logic op_is_load(input acc_op_e op);
        op_is_load = (op == OP_LB) || (op == OP_LBU) || (op == OP_LH) ||
                     (op == OP_LHU) || (op == OP_LW);
    endfunction

    // True for the three store codes.
    function automatic logic op_is_store(input acc_op_e op);
        op_is_store = (op == OP_SB) || (op == OP_SH) || (op == OP_SW);
    endfunction

    // True for loads that sign-extend.
    function automatic logic op_is_signed(input acc_op_e op);
        op_is_signed = (op == OP_LB) || (op == OP_LH);
    endfunction

endpackage

// File: rtl/lane_addr_gen.sv
// Module: forms the effective byte address from base plus signed displacement
// and flags accesses whose address is not a multiple of their size.
// Assumes halfwords span two lanes and words span all lanes.
module lane_addr_gen
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [OFFS_W-1:0] offset,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              misaligned
);
    localparam int LANE_BITS = $clog2(LANES);

    logic [ADDR_W-1:0] offs_ext;

    // Sign-extend the displacement and add it to the base.
    always_comb begin
        offs_ext = {{(ADDR_W-OFFS_W){offset[OFFS_W-1]}}, offset};
        eff_addr = base_addr + offs_ext;
    end

    // Alignment check by size class.
    always_comb begin
        case (size)
            SZ_HALF: misaligned = eff_addr[0];
            SZ_WORD: misaligned = (eff_addr[LANE_BITS-1:0] != '0);
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/lane_store_pack.sv
// Module: replicates store data across all byte lanes and raises the write
// strobes that cover the addressed bytes. Little-endian lane numbering.
// Assumes the caller has already gated 'en' with validity and alignment.
module lane_store_pack
    import lane_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                  en,
    input  acc_size_e             size,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [LANES*8-1:0]    st_data,
    output logic [LANES-1:0]      wstrb,
    output logic [LANES*8-1:0]    wdata
);
    localparam int LANE_BITS = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit_byte;
        logic hit_half;

        // Which size classes address this lane.
        assign hit_byte = (lane == LANE_BITS'(g));
        assign hit_half = (lane[LANE_BITS-1:1] == (LANE_BITS-1)'(g / 2));

        // Strobe for this lane.
        always_comb begin
            case (size)
                SZ_BYTE: wstrb[g] = en && hit_byte;
                SZ_HALF: wstrb[g] = en && hit_half;
                SZ_WORD: wstrb[g] = en;
                default: wstrb[g] = 1'b0;
            endcase
        end

        // Data for this lane: low byte, matching half byte, or own byte.
        always_comb begin
            case (size)
                SZ_BYTE: wdata[g*8 +: 8] = st_data[7:0];
                SZ_HALF: wdata[g*8 +: 8] = st_data[(g % 2)*8 +: 8];
                default: wdata[g*8 +: 8] = st_data[g*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lane_load_extract.sv
// Module: selects the addressed byte or halfword from a returned word and
// extends it to full width; word loads pass through.
// Assumes the lane has already been checked for alignment.
module lane_load_extract
    import lane_pkg::*;
#(
    parameter int LANES = 4
) (
    input  acc_size_e                size,
    input  logic                     sgn,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [LANES*8-1:0]       word,
    output logic [LANES*8-1:0]       result
);
    localparam int DATA_W    = LANES * 8;
    localparam int LANE_BITS = $clog2(LANES);

    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    // Pick the field by lane index.
    always_comb begin
        sel_b = word[lane*8 +: 8];
        sel_h = word[lane[LANE_BITS-1:1]*16 +: 16];
    end

    // Extend according to size and signedness.
    always_comb begin
        case (size)
            SZ_BYTE: result = {{(DATA_W-8){sgn && sel_b[7]}}, sel_b};
            SZ_HALF: result = {{(DATA_W-16){sgn && sel_h[15]}}, sel_h};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/mem_lane_align.sv
// Module: top of the load/store lane aligner. Computes the address, packs
// stores, tracks one pending load and registers the load or upper-immediate
// result. Assumes at most one read return per accepted load.
module mem_lane_align
    import lane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    parameter int LANES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [3:0]          req_op,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [OFFS_W-1:0]   offset,
    input  logic [LANES*8-1:0]  st_data,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LANES-1:0]    mem_wstrb,
    output logic [LANES*8-1:0]  mem_wdata,
    output logic                req_err,
    input  logic                rd_valid,
    input  logic [LANES*8-1:0]  rd_word,
    output logic                res_valid,
    output logic [LANES*8-1:0]  res_data
);
    localparam int DATA_W    = LANES * 8;
    localparam int LANE_BITS = $clog2(LANES);

    acc_op_e             op;
    acc_size_e           sz;
    logic                misal;
    logic                is_ld;
    logic                is_st;
    logic                lui_take;
    logic                st_en;
    logic                ret_take;
    logic                pend_q;
    acc_size_e           pend_sz_q;
    logic                pend_sgn_q;
    logic [LANE_BITS-1:0] pend_lane_q;
    logic [DATA_W-1:0]   ld_val;

    // Decode the request.
    always_comb begin
        op       = acc_op_e'(req_op);
        sz       = op_size(op);
        is_ld    = req_valid && op_is_load(op);
        is_st    = req_valid && op_is_store(op);
        lui_take = req_valid && (op == OP_LUI);
        req_err  = (is_ld || is_st) && misal;
        st_en    = is_st && !misal;
        ret_take = rd_valid && pend_q;
    end

    lane_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .LANES  (LANES)
    ) u_addr (
        .base_addr  (base_addr),
        .offset     (offset),
        .size       (sz),
        .eff_addr   (mem_addr),
        .misaligned (misal)
    );

    lane_store_pack #(
        .LANES (LANES)
    ) u_store (
        .en      (st_en),
        .size    (sz),
        .lane    (mem_addr[LANE_BITS-1:0]),
        .st_data (st_data),
        .wstrb   (mem_wstrb),
        .wdata   (mem_wdata)
    );

    lane_load_extract #(
        .LANES (LANES)
    ) u_load (
        .size   (pend_sz_q),
        .sgn    (pend_sgn_q),
        .lane   (pend_lane_q),
        .word   (rd_word),
        .result (ld_val)
    );

    // Track the outstanding load: a new aligned load overwrites, a return clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_sz_q   <= SZ_WORD;
            pend_sgn_q  <= 1'b0;
            pend_lane_q <= '0;
        end else if (is_ld && !misal) begin
            pend_q      <= 1'b1;
            pend_sz_q   <= sz;
            pend_sgn_q  <= op_is_signed(op);
            pend_lane_q <= mem_addr[LANE_BITS-1:0];
        end else if (rd_valid) begin
            pend_q      <= 1'b0;
        end
    end

    // Register the result: read return has priority over upper immediate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else if (ret_take) begin
            res_valid <= 1'b1;
            res_data  <= ld_val;
        end else if (lui_take) begin
            res_valid <= 1'b1;
            res_data  <= {offset, {(DATA_W-OFFS_W){1'b0}}};
        end else begin
            res_valid <= 1'b0;
        end
    end

    // A flagged access must not reach memory.
    p_err_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (mem_wstrb == '0));

    // Any write uses one, two or all lanes.
    p_strobe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wstrb != '0) |-> ($countones(mem_wstrb) == 1 ||
                               $countones(mem_wstrb) == 2 ||
                               $countones(mem_wstrb) == LANES));

    // Non-store codes never write.
    p_no_write_nonstore_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && op_is_store(acc_op_e'(req_op))) |-> (mem_wstrb == '0));

    // A result only follows a matched return or an upper-immediate request.
    p_result_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(ret_take || lui_take));

    // A misaligned load leaves nothing pending.
    p_err_no_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_err && !rd_valid && !pend_q) |=> !pend_q);

    // Upper immediate clears the low half.
    p_lui_low_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lui_take && !ret_take) |=> (res_valid && res_data[DATA_W-OFFS_W-1:0] == '0));
endmodule

// File: tb/mem_lane_align_tb_top.sv
// Bench: behavioural reference model checked every clock.
module mem_lane_align_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_op = 4'd0;
    logic [31:0] base_addr = '0;
    logic [15:0] offset = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic        req_err;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_word = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int n_vec = 0;
    int n_bad = 0;

    // Model state
    bit          m_pend = 0;
    int          m_op = 0;
    int          m_lane = 0;
    bit          exp_rv = 0;
    logic [31:0] exp_rd = '0;
    string       prev_tag = "R11";
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    mem_lane_align dut_i (
        .clk, .rst_n, .req_valid, .req_op, .base_addr, .offset, .st_data,
        .mem_addr, .mem_wstrb, .mem_wdata, .req_err,
        .rd_valid, .rd_word, .res_valid, .res_data
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_load(input int op, input int lane, input logic [31:0] w);
        logic [31:0] sh;
        sh = w >> (8 * lane);
        case (op)
            0: return {{24{sh[7]}}, sh[7:0]};
            1: return {24'h0, sh[7:0]};
            2: return {{16{sh[15]}}, sh[15:0]};
            3: return {16'h0, sh[15:0]};
            default: return w;
        endcase
    endfunction

    task automatic cycle(input bit v, input int op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] sd,
                         input bit rdv, input logic [31:0] rw, input string tag);
        logic [31:0] ea;
        int lane, size;
        bit is_ld, is_st, mis;
        logic [3:0] es;
        logic [31:0] ed;
        bit nv;
        logic [31:0] nd;
        @(negedge clk);
        chk({prev_tag, " res_valid (R9)"}, {31'h0, res_valid}, {31'h0, exp_rv});
        if (exp_rv) chk({prev_tag, " res_data"}, res_data, exp_rd);
        req_valid = v; req_op = 4'(op); base_addr = base; offset = off;
        st_data = sd; rd_valid = rdv; rd_word = rw;
        #1;
        ea    = base + {{16{off[15]}}, off};
        lane  = int'(ea[1:0]);
        is_ld = v && (op <= 4);
        is_st = v && (op >= 8 && op <= 10);
        size  = (op == 0 || op == 1 || op == 8) ? 1 : (op == 2 || op == 3 || op == 9) ? 2 : 4;
        mis   = (is_ld || is_st) && ((size == 2 && ea[0]) || (size == 4 && ea[1:0] != 0));
        es = 4'h0; ed = sd;
        if (is_st && !mis) begin
            if (size == 1) begin es = 4'(1 << lane); ed = {4{sd[7:0]}}; end
            else if (size == 2) begin es = ea[1] ? 4'b1100 : 4'b0011; ed = {2{sd[15:0]}}; end
            else es = 4'b1111;
        end
        chk("R1 mem_addr", mem_addr, ea);
        chk({tag, " req_err (R5)"}, {31'h0, req_err}, {31'h0, mis});
        chk({tag, " mem_wstrb (R12)"}, {28'h0, mem_wstrb}, {28'h0, es});
        if (es != 0) chk({tag, " mem_wdata"}, mem_wdata, ed);
        // Next registered result
        nv = 0; nd = '0;
        if (rdv && m_pend) begin nv = 1; nd = model_load(m_op, m_lane, rw); end
        else if (v && op == 12) begin nv = 1; nd = {off, 16'h0}; end
        if (is_ld && !mis) begin m_pend = 1; m_op = op; m_lane = lane; end
        else if (rdv) m_pend = 0;
        exp_rv = nv; exp_rd = nd; prev_tag = tag;
    endtask

    task automatic idle(input string tag);
        cycle(0, 0, 32'h0, 16'h0, 32'h0, 0, 32'h0, tag);
    endtask

    task automatic load(input int op, input logic [31:0] addr, input logic [31:0] w, input string tag);
        cycle(1, op, addr, 16'h0, 32'h0, 0, 32'h0, tag);
        cycle(0, 0, 32'h0, 16'h0, 32'h0, 1, w, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11 res_valid in reset", {31'h0, res_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R11");
        idle("R11");
        // R1 and R4: negative displacement, aligned word store
        cycle(1, 10, 32'h0000_1000, 16'hFFFC, 32'hDEAD_BEEF, 0, 0, "R4");
        cycle(1, 10, 32'h0000_1000, 16'h7FF0, 32'h0123_4567, 0, 0, "R4");
        // R2: byte stores on each lane
        for (int k = 0; k < 4; k++)
            cycle(1, 8, 32'h0000_2000 + 32'(k), 16'h0, 32'h1122_33A5, 0, 0, "R2");
        // R3: halfword stores, both halves
        cycle(1, 9, 32'h0000_2000, 16'h0, 32'hFFFF_C3D4, 0, 0, "R3");
        cycle(1, 9, 32'h0000_2000, 16'h2, 32'hFFFF_C3D4, 0, 0, "R3");
        // R5: misaligned stores and loads
        cycle(1, 9, 32'h0000_2001, 16'h0, 32'h5555_5555, 0, 0, "R5");
        cycle(1, 10, 32'h0000_2002, 16'h0, 32'h5555_5555, 0, 0, "R5");
        cycle(1, 2, 32'h0000_2003, 16'h0, 32'h0, 0, 0, "R5");
        cycle(0, 0, 32'h0, 16'h0, 32'h0, 1, 32'h8000_8000, "R5");
        idle("R5");
        // R9: stray return
        cycle(0, 0, 32'h0, 16'h0, 32'h0, 1, 32'hFFFF_FFFF, "R9");
        idle("R9");
        // R6: byte loads on each lane, both patterns
        for (int k = 0; k < 4; k++) begin
            load(0, 32'h0000_3000 + 32'(k), 32'h80FF_7F01, "R6");
            load(1, 32'h0000_3000 + 32'(k), 32'h80FF_7F01, "R6");
            load(0, 32'h0000_3000 + 32'(k), 32'h7F80_01FE, "R6");
        end
        // R7: halfword loads
        load(2, 32'h0000_3000, 32'h1234_8001, "R7");
        load(3, 32'h0000_3000, 32'h1234_8001, "R7");
        load(2, 32'h0000_3002, 32'hF00D_8001, "R7");
        load(3, 32'h0000_3002, 32'hF00D_8001, "R7");
        load(2, 32'h0000_3002, 32'h7FFF_FFFF, "R7");
        // R8: word load
        load(4, 32'h0000_3004, 32'hCAFE_F00D, "R8");
        // R10: upper immediate, and collision with a return
        cycle(1, 12, 32'h0, 16'hBEEF, 32'h0, 0, 0, "R10");
        cycle(1, 12, 32'h0, 16'h0001, 32'h0, 0, 0, "R10");
        cycle(1, 4, 32'h0000_4000, 16'h0, 32'h0, 0, 0, "R10");
        cycle(1, 12, 32'h0, 16'h7777, 32'h0, 1, 32'h0A0B_0C0D, "R10");
        // R12: unassigned code
        cycle(1, 6, 32'h0000_5000, 16'h0, 32'hFFFF_FFFF, 0, 0, "R12");
        cycle(1, 15, 32'h0000_5001, 16'h0, 32'hFFFF_FFFF, 0, 0, "R12");
        idle("R12");
        // Mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            int ops[10] = '{0, 1, 2, 3, 4, 8, 9, 10, 12, 5};
            logic [31:0] a, d, w;
            lcg = lcg * 32'd1664525 + 32'd1013904223; a = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223; d = lcg;
            lcg = lcg * 32'd1664525 + 32'd1013904223; w = lcg;
            cycle(a[31], ops[int'(d[31:28]) % 10], {a[30:0], 1'b0} ^ {30'h0, a[3:2]},
                  d[15:0], w ^ d, w[0], w, "R9 random");
        end
        idle("R9");
        idle("R9");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule